// File: doc/BRIEF.md
# Logarithm-Table Prime Modulus Multiplier

This block multiplies two residues modulo a small prime without any multiplier array. A nonzero residue is turned into its discrete logarithm with respect to a primitive root by a small combinational lookup. The two logarithms are added, and a second lookup raises the root to that sum, which gives the product. If either operand is zero, no logarithm exists. In that case the lookup path is skipped and the product is forced to zero.

The exponent lookup is built with about twice as many entries as there are residues, so it accepts the raw sum of two logarithms. No wrap-around comparison or reduction multiplexer follows the adder. Both lookups are computed at elaboration from the modulus and root parameters, and they synthesize to plain logic. The result is registered once. Each accepted operand pair yields a product and a valid flag on the next clock edge.

Top module: `idx_mod_mult`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted pair, `out_valid` is 0 and `out_prod` is 0.
- R2: `out_valid` equals the value that `in_valid` had at the previous rising clock edge.
- R3: When `in_valid` is 1 and both operands are nonzero, `out_prod` after the next edge equals (`in_a` * `in_b`) mod MOD.
- R4: When `in_valid` is 1 and either operand is 0, `out_prod` after the next edge is 0.
- R5: When `in_valid` is 0, `out_prod` keeps its previous value, whatever the operands are.
- R6: `out_prod` is always below MOD.
- R7: A product of two nonzero operands is never 0, because MOD is prime.
- R8: When `in_a` is 1, the product equals `in_b`.
- R9: The block is correct for any prime MOD from 3 to 63 together with a primitive root ROOT. This is shown for MOD of 11, 13 and 29 with ROOT 2, over every pair of residues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_a | input | $clog2(MOD) | First residue, below MOD |
| in_b | input | $clog2(MOD) | Second residue, below MOD |
| out_valid | output | 1 | Product register was loaded on the last edge |
| out_prod | output | $clog2(MOD) | Registered modular product |

## Verification
The checker watches the following on every cycle:
- the one-cycle valid pipeline;
- the forced zero when an operand is zero;
- that the product holds while no pair is offered;
- that the result stays in range and is nonzero for nonzero operands;
- the identity case, where one operand is 1.

These properties do not show that the lookup contents are right. Only the bench's full sweep of every residue pair, at three different prime moduli, shows that each logarithm and each power is the correct one. The same applies to the reset value and to directed pairs whose logarithms sum near the top of the exponent range.

// File: rtl/idx_mod_mult.sv
module idx_mod_mult #(
  parameter int MOD  = 11,
  parameter int ROOT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [$clog2(MOD)-1:0] in_a,
  input  logic [$clog2(MOD)-1:0] in_b,
  output logic                   out_valid,
  output logic [$clog2(MOD)-1:0] out_prod
);
  localparam int W    = $clog2(MOD);
  localparam int LW   = $clog2(MOD - 1);
  localparam int NEXP = 2 * MOD - 3;
  localparam int SW   = $clog2(NEXP);

  function automatic int pow_root(int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * ROOT) % MOD;
    return r;
  endfunction

  function automatic int log_root(int v);
    int r = 0;
    for (int k = 0; k < MOD - 1; k++)
      if (pow_root(k) == v) r = k;
    return r;
  endfunction

  logic [LW-1:0] log_tab [2**W];
  logic [W-1:0]  exp_tab [2**SW];

  for (genvar v = 0; v < 2**W; v++) begin : g_log
    localparam int L = (v >= 1 && v < MOD) ? log_root(v) : 0;
    assign log_tab[v] = LW'(L);
  end

  for (genvar s = 0; s < 2**SW; s++) begin : g_exp
    localparam int P = (s < NEXP) ? pow_root(s % (MOD - 1)) : 0;
    assign exp_tab[s] = W'(P);
  end

  logic [SW-1:0] idx_sum;
  logic          zero_op;
  logic [W-1:0]  prod_next;

  assign idx_sum   = SW'(log_tab[in_a]) + SW'(log_tab[in_b]);
  assign zero_op   = (in_a == '0) || (in_b == '0);
  assign prod_next = zero_op ? '0 : exp_tab[idx_sum];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_prod <= prod_next;
    end
  end
endmodule

// File: rtl/idx_mod_mult_chk.sv
module idx_mod_mult_chk #(
  parameter int MOD = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [$clog2(MOD)-1:0] in_a,
  input logic [$clog2(MOD)-1:0] in_b,
  input logic                   out_valid,
  input logic [$clog2(MOD)-1:0] out_prod
);
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a == '0 || in_b == '0)) |=> (out_prod == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_prod)); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(out_prod) < MOD); // R6
  AST_NONZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a != '0 && in_b != '0) |=> (out_prod != '0)); // R7
  AST_UNIT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a == 1) |=> (out_prod == $past(in_b))); // R8
endmodule

bind idx_mod_mult idx_mod_mult_chk #(.MOD(MOD)) u_chk (.*);

// File: tb/test_idx_mod_mult.sv
module test_idx_mod_mult;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       v_in = 1'b0;
  logic [3:0] a11 = '0, b11 = '0, a13 = '0, b13 = '0;
  logic [4:0] a29 = '0, b29 = '0;
  logic       v11, v13, v29;
  logic [3:0] p11, p13;
  logic [4:0] p29;

  idx_mod_mult #(.MOD(11), .ROOT(2)) i_idx_mod_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(v_in), .in_a(a11), .in_b(b11),
    .out_valid(v11), .out_prod(p11));
  idx_mod_mult #(.MOD(13), .ROOT(2)) i_idx_mod_mult_13 (
    .clk(clk), .rst_n(rst_n), .in_valid(v_in), .in_a(a13), .in_b(b13),
    .out_valid(v13), .out_prod(p13));
  idx_mod_mult #(.MOD(29), .ROOT(2)) i_idx_mod_mult_29 (
    .clk(clk), .rst_n(rst_n), .in_valid(v_in), .in_a(a29), .in_b(b29),
    .out_valid(v29), .out_prod(p29));

  int checks = 0;
  int errors = 0;

  // {a, b, expected} for modulus 11
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {4'd3, 4'd4, 4'd1}, {4'd7, 4'd8, 4'd1}, {4'd10, 4'd10, 4'd1},
    {4'd5, 4'd9, 4'd1}, {4'd6, 4'd6, 4'd3}, {4'd2, 4'd9, 4'd7},
    {4'd0, 4'd7, 4'd0}, {4'd9, 4'd0, 4'd0}, {4'd1, 4'd6, 4'd6},
    {4'd8, 4'd7, 4'd1}};

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int a, int b, bit v);
    @(negedge clk);
    v_in = v;
    a11 = 4'(a % 11); b11 = 4'(b % 11);
    a13 = 4'(a % 13); b13 = 4'(b % 13);
    a29 = 5'(a % 29); b29 = 5'(b % 29);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(v11 == 0 && v13 == 0 && v29 == 0, "R1", int'(v11), 0);
    chk(p11 == 0 && p13 == 0 && p29 == 0, "R1", int'(p29), 0);
    drive(5, 7, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(p11 == 0 && v11 == 0, "R1", int'(p11), 0);

    // table of vectors, modulus 11 (R3, R4, R8)
    for (int i = 0; i < NV; i++) begin
      drive(int'(VEC[i][11:8]), int'(VEC[i][7:4]), 1'b1);
      @(negedge clk);
      chk(p11 == VEC[i][3:0], "R3", int'(p11), int'(VEC[i][3:0]));
      chk(v11 == 1'b1, "R2", int'(v11), 1);
    end

    // R9 exhaustive sweep across all three moduli
    for (int a = 0; a < 29; a++) begin
      for (int b = 0; b < 29; b++) begin
        drive(a, b, 1'b1);
        @(negedge clk);
        chk(int'(p11) == ((a % 11) * (b % 11)) % 11, "R9", int'(p11), ((a % 11) * (b % 11)) % 11);
        chk(int'(p13) == ((a % 13) * (b % 13)) % 13, "R9", int'(p13), ((a % 13) * (b % 13)) % 13);
        chk(int'(p29) == (a * b) % 29, "R9", int'(p29), (a * b) % 29);
      end
    end

    // R5: idle cycles hold the product, R2: valid drops
    drive(28, 28, 1'b1);
    @(negedge clk);
    hold = int'(p29);
    chk(hold == 1, "R3", hold, 1);
    drive(3, 5, 1'b0);
    @(negedge clk);
    chk(int'(p29) == hold, "R5", int'(p29), hold);
    chk(v29 == 1'b0, "R2", int'(v29), 0);
    drive(0, 0, 1'b0);
    @(negedge clk);
    chk(int'(p29) == hold, "R5", int'(p29), hold);

    // R4: zero operand after a nonzero product
    drive(27, 0, 1'b1);
    @(negedge clk);
    chk(p29 == 0 && p11 == 0 && p13 == 0, "R4", int'(p29), 0);

    // R8: unit operand passes the other through
    drive(1, 12, 1'b1);
    @(negedge clk);
    chk(int'(p13) == 12, "R8", int'(p13), 12);

    // R7: largest logarithm sum stays nonzero
    drive(15, 15, 1'b1);
    @(negedge clk);
    chk(int'(p29) == (15 * 15) % 29, "R7", int'(p29), (15 * 15) % 29);

    // R1: reset clears again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(p29 == 0 && v29 == 0, "R1", int'(p29), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule